// File: doc/BRIEF.md
# Condition Register Compare Unit

This block keeps a 32-bit condition register made of eight 4-bit result fields. An integer compare takes two signed words, or a word and a sign-extended 16-bit immediate. It writes an ordering code and a copy of a summary-overflow input into one chosen field. No other field changes.

The same register serves two other kinds of operation. Bit-level AND, OR and XOR combine any two register bits and write the result into a third bit. Branch checks test one bit of a chosen field and report the outcome combinationally on `br_taken`. The whole register is always visible on `cr_value`. Only one operation is presented per cycle, qualified by `op_valid`. Register writes take effect at the next rising clock edge.

Top module: `crcu_top`

## Requirements
- R1: Reset sets all 32 register bits to zero. Reset is asynchronous, active low, and its release is synchronised to the clock.
- R2: Opcode encodings: 0 no-op, 1 compare with `opnd_b`, 2 compare with immediate. A compare writes the three high bits of field `fld_sel`. The code is 100 when `opnd_a` is less, 010 when it is greater and 001 when the operands are equal. Field f occupies `cr_value[31-4f:28-4f]`. Both operands are signed two's-complement values.
- R3: The immediate compare (opcode 2) sign-extends `imm` to 32 bits before the comparison.
- R4: Every compare copies `so_in` into the lowest bit of the written field (`cr_value[28-4f]`).
- R5: A compare leaves all bits outside the selected field unchanged.
- R6: Opcodes 3, 4 and 5 set bit `bit_d` to the AND, OR or XOR of bits `bit_a` and `bit_b`. Bit indices count from the most significant end, so index i is `cr_value[31-i]`. No other bit changes.
- R7: An XOR whose two source indices are equal clears the destination bit.
- R8: Opcode 6 (not-equal test) drives `br_taken` high when bit `cr_value[29-4f]` of field `fld_sel` is clear. Opcode 7 (less-or-equal test) drives it high when `cr_value[30-4f]` is clear. `br_taken` is low for every other opcode and while `op_valid` is low. A branch test never changes the register.
- R9: While `op_valid` is low, the register holds its value whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation qualifier |
| opcode | input | 3 | Operation select |
| opnd_a | input | 32 | Left compare operand |
| opnd_b | input | 32 | Right compare operand (register form) |
| imm | input | 16 | Immediate compare operand |
| fld_sel | input | 3 | Field index for compares and branch tests |
| so_in | input | 1 | Summary-overflow value stored by compares |
| bit_a | input | 5 | First source bit index |
| bit_b | input | 5 | Second source bit index |
| bit_d | input | 5 | Destination bit index |
| br_taken | output | 1 | Branch condition result |
| cr_value | output | 32 | Current register contents |

## Verification
The embedded properties cover the structural rules that must hold after every edge:
- the written ordering code is one-hot;
- the overflow copy is stored;
- bits outside a compared field stay put;
- XOR of a bit with itself clears it;
- the register stays still through idle cycles and branch tests;
- the register is zero when reset releases.

Several behaviours are shown only by the bench's scenarios, where a reference model predicts every field:
- the signed ordering of extreme operands;
- sign extension of immediates such as 0x8000;
- the big-endian placement of fields and bit indices;
- the exact AND and OR results;
- the branch polarities.

// File: rtl/crcu_pkg.sv
package crcu_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_CMP_RR = 3'd1,
    OP_CMP_RI = 3'd2,
    OP_AND    = 3'd3,
    OP_OR     = 3'd4,
    OP_XOR    = 3'd5,
    OP_BNE    = 3'd6,
    OP_BLE    = 3'd7
  } crcu_op_e;
endpackage

// File: rtl/crcu_rst_sync.sv
module crcu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/crcu_cmp.sv
module crcu_cmp #(
  parameter int unsigned DATA_W = 32,
  parameter bit          SIGNED = 1'b1
) (
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  output logic              lt_o,
  output logic              gt_o,
  output logic              eq_o
);
  generate
    if (SIGNED) begin : g_signed
      assign lt_o = $signed(lhs) < $signed(rhs);
      assign gt_o = $signed(lhs) > $signed(rhs);
    end else begin : g_unsigned
      assign lt_o = lhs < rhs;
      assign gt_o = lhs > rhs;
    end
  endgenerate

  assign eq_o = (lhs == rhs);
endmodule

// File: rtl/crcu_bitop.sv
module crcu_bitop
  import crcu_pkg::*;
#(
  parameter int unsigned CR_W  = 32,
  parameter int unsigned IDX_W = 5
) (
  input  logic [CR_W-1:0]  cr_i,
  input  logic [IDX_W-1:0] idx_a,
  input  logic [IDX_W-1:0] idx_b,
  input  crcu_op_e         op_i,
  output logic             res_o
);
  logic src_a, src_b;

  // big-endian bit numbering: index 0 is the most significant bit
  assign src_a = cr_i[IDX_W'(CR_W-1) - idx_a];
  assign src_b = cr_i[IDX_W'(CR_W-1) - idx_b];

  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = src_a & src_b;
      OP_OR:   res_o = src_a | src_b;
      OP_XOR:  res_o = src_a ^ src_b;
      default: res_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/crcu_top.sv
module crcu_top
  import crcu_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned IMM_W       = 16,
  parameter int unsigned FIELDS      = 8,
  parameter int unsigned FLD_W       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CR_W  = FIELDS * FLD_W,
  localparam int unsigned IDX_W = $clog2(CR_W),
  localparam int unsigned SEL_W = $clog2(FIELDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        opcode,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic [SEL_W-1:0]  fld_sel,
  input  logic              so_in,
  input  logic [IDX_W-1:0]  bit_a,
  input  logic [IDX_W-1:0]  bit_b,
  input  logic [IDX_W-1:0]  bit_d,
  output logic              br_taken,
  output logic [CR_W-1:0]   cr_value
);
  logic              rst_s_n;
  crcu_op_e          op;
  logic [DATA_W-1:0] rhs;
  logic              lt, gt, eq;
  logic              is_cmp, is_bit, is_br;
  logic [IDX_W-1:0]  fld_base, dst_pos;
  logic [CR_W-1:0]   fld_mask;
  logic              bit_res;
  logic              cr_en;
  logic [CR_W-1:0]   cr_d, cr_q;
  logic              eq_bit, gt_bit;

  crcu_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_s_n)
  );

  assign op     = crcu_op_e'(opcode);
  assign is_cmp = (op == OP_CMP_RR) || (op == OP_CMP_RI);
  assign is_bit = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  assign is_br  = (op == OP_BNE) || (op == OP_BLE);

  // immediate form: sign-extend before the compare
  assign rhs = (op == OP_CMP_RI) ? {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm} : opnd_b;

  crcu_cmp #(.DATA_W(DATA_W), .SIGNED(1'b1)) u_cmp (
    .lhs  (opnd_a),
    .rhs  (rhs),
    .lt_o (lt),
    .gt_o (gt),
    .eq_o (eq)
  );

  crcu_bitop #(.CR_W(CR_W), .IDX_W(IDX_W)) u_bitop (
    .cr_i  (cr_q),
    .idx_a (bit_a),
    .idx_b (bit_b),
    .op_i  (op),
    .res_o (bit_res)
  );

  // field 0 sits at the top of the register
  assign fld_base = IDX_W'(CR_W-1) - IDX_W'(FLD_W * fld_sel);
  assign fld_mask = CR_W'({FLD_W{1'b1}}) << (fld_base - IDX_W'(FLD_W-1));
  assign dst_pos  = IDX_W'(CR_W-1) - bit_d;

  // next-state
  assign cr_en = op_valid && (is_cmp || is_bit);

  always_comb begin
    cr_d = cr_q;
    if (is_cmp)      cr_d[fld_base -: FLD_W] = FLD_W'({lt, gt, eq, so_in});
    else if (is_bit) cr_d[dst_pos]           = bit_res;
  end

  // state register
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)   cr_q <= '0;
    else if (cr_en) cr_q <= cr_d;
  end

  // branch evaluation on the current register contents
  assign gt_bit   = cr_q[fld_base - IDX_W'(1)];
  assign eq_bit   = cr_q[fld_base - IDX_W'(2)];
  assign br_taken = op_valid && (((op == OP_BNE) && !eq_bit) || ((op == OP_BLE) && !gt_bit));

  assign cr_value = cr_q;

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_s_n) |-> (cr_q == '0));

  assert_cmp_code_onehot_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (op_valid && is_cmp) |=> $onehot(cr_q[$past(fld_base) -: 3]));

  assert_so_copy_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (op_valid && is_cmp) |=> (cr_q[$past(fld_base) - IDX_W'(3)] == $past(so_in)));

  assert_other_fields_kept_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (op_valid && is_cmp) |=> (((cr_q ^ $past(cr_q)) & ~$past(fld_mask)) == '0));

  assert_xor_self_clears_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (op_valid && (op == OP_XOR) && (bit_a == bit_b)) |=> !cr_q[$past(dst_pos)]);

  assert_branch_no_write_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (op_valid && is_br) |=> $stable(cr_q));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    !op_valid |=> $stable(cr_q));
endmodule

// File: tb/crcu_top_tb.sv
`timescale 1ns/1ps
module crcu_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  opcode;
  logic [31:0] opnd_a, opnd_b;
  logic [15:0] imm;
  logic [2:0]  fld_sel;
  logic        so_in;
  logic [4:0]  bit_a, bit_b, bit_d;
  logic        br_taken;
  logic [31:0] cr_value;

  int          n_cmp = 0;
  int          n_bad = 0;
  logic [31:0] mdl;

  always #2.5 clk = ~clk;

  crcu_top u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .imm(imm), .fld_sel(fld_sel),
    .so_in(so_in), .bit_a(bit_a), .bit_b(bit_b), .bit_d(bit_d),
    .br_taken(br_taken), .cr_value(cr_value)
  );

  function automatic logic [2:0] ord_code(logic [31:0] a, logic [31:0] b);
    if ($signed(a) < $signed(b))      return 3'b100;
    else if ($signed(a) > $signed(b)) return 3'b010;
    else                              return 3'b001;
  endfunction

  function automatic logic [31:0] model_next(logic [31:0] cur, logic v, logic [2:0] opc,
      logic [31:0] a, logic [31:0] b, logic [15:0] im, logic [2:0] f, logic so,
      logic [4:0] ia, logic [4:0] ib, logic [4:0] id);
    logic [31:0] r;
    logic        x, y;
    int          p;
    r = cur;
    p = 31 - 4 * int'(f);
    x = cur[31 - int'(ia)];
    y = cur[31 - int'(ib)];
    if (v) begin
      case (opc)
        3'd1: r[p -: 4] = {ord_code(a, b), so};
        3'd2: r[p -: 4] = {ord_code(a, {{16{im[15]}}, im}), so};
        3'd3: r[31 - int'(id)] = x & y;
        3'd4: r[31 - int'(id)] = x | y;
        3'd5: r[31 - int'(id)] = x ^ y;
        default: ;
      endcase
    end
    return r;
  endfunction

  function automatic logic model_br(logic [31:0] cur, logic v, logic [2:0] opc, logic [2:0] f);
    int p;
    p = 31 - 4 * int'(f);
    if (!v) return 1'b0;
    if (opc == 3'd6) return !cur[p - 2];
    if (opc == 3'd7) return !cur[p - 1];
    return 1'b0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(string req, logic v, logic [2:0] opc, logic [31:0] a, logic [31:0] b,
      logic [15:0] im, logic [2:0] f, logic so, logic [4:0] ia, logic [4:0] ib, logic [4:0] id);
    logic [31:0] nxt;
    @(negedge clk);
    op_valid = v; opcode = opc; opnd_a = a; opnd_b = b; imm = im;
    fld_sel = f; so_in = so; bit_a = ia; bit_b = ib; bit_d = id;
    #1;
    chk({req, " br_taken (R8)"}, {31'd0, br_taken}, {31'd0, model_br(mdl, v, opc, f)});
    nxt = model_next(mdl, v, opc, a, b, im, f, so, ia, ib, id);
    @(posedge clk);
    #1;
    op_valid = 1'b0;
    mdl = nxt;
    chk(req, cr_value, mdl);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0c0d));
    rst_n = 1'b0; op_valid = 1'b0; opcode = '0; opnd_a = '0; opnd_b = '0; imm = '0;
    fld_sel = '0; so_in = 1'b0; bit_a = '0; bit_b = '0; bit_d = '0;
    mdl = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 reset value", cr_value, 32'h0);

    // R2 signed ordering at the extremes, field 0 at the top
    run_op("R2 min<1 field0",   1, 3'd1, 32'h8000_0000, 32'h1, 16'h0, 3'd0, 1'b0, 0, 0, 0);
    chk("R2 field0 code", cr_value, 32'h8000_0000);
    // R4 overflow copy, field 7 at the bottom
    run_op("R4 1>-1 field7",    1, 3'd1, 32'h1, 32'hFFFF_FFFF, 16'h0, 3'd7, 1'b1, 0, 0, 0);
    chk("R4 field7 code", cr_value, 32'h8000_0005);
    // R3 sign extension
    run_op("R3 imm 0x8000 equal", 1, 3'd2, 32'hFFFF_8000, 32'h0, 16'h8000, 3'd3, 1'b0, 0, 0, 0);
    chk("R3 field3 eq", cr_value & 32'h000F_0000, 32'h0002_0000);
    run_op("R3 5 > imm -1",     1, 3'd2, 32'h5, 32'h0, 16'hFFFF, 3'd4, 1'b0, 0, 0, 0);
    chk("R3 field4 gt", cr_value & 32'h0000_F000, 32'h0000_4000);
    // R5 other fields untouched
    run_op("R5 rewrite field3", 1, 3'd1, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 3'd3, 1'b1, 0, 0, 0);
    chk("R5 outside field3", cr_value & 32'hFFF0_FFFF, 32'h8000_4005);
    // R9 idle with compare opcode
    run_op("R9 idle hold",      0, 3'd1, 32'h0, 32'h0, 16'h0, 3'd1, 1'b1, 0, 0, 0);
    // R7 xor self on bit 0
    run_op("R7 xor self bit0",  1, 3'd5, 32'h0, 32'h0, 16'h0, 3'd0, 1'b0, 5'd0, 5'd0, 5'd0);
    chk("R7 bit0 cleared", cr_value & 32'h8000_0000, 32'h0);
    // R6 or / and with big-endian indices
    run_op("R6 or into bit1",   1, 3'd4, 32'h0, 32'h0, 16'h0, 3'd0, 1'b0, 5'd31, 5'd29, 5'd1);
    chk("R6 bit1 set", cr_value & 32'h4000_0000, 32'h4000_0000);
    run_op("R6 and into bit2",  1, 3'd3, 32'h0, 32'h0, 16'h0, 3'd0, 1'b0, 5'd1, 5'd31, 5'd2);
    // R8 branch tests
    run_op("R8 bne field3",     1, 3'd6, 32'h0, 32'h0, 16'h0, 3'd3, 1'b0, 0, 0, 0);
    run_op("R8 ble field3",     1, 3'd7, 32'h0, 32'h0, 16'h0, 3'd3, 1'b0, 0, 0, 0);
    run_op("R8 ble field4",     1, 3'd7, 32'h0, 32'h0, 16'h0, 3'd4, 1'b0, 0, 0, 0);
    run_op("R8 bne idle",       0, 3'd6, 32'h0, 32'h0, 16'h0, 3'd2, 1'b0, 0, 0, 0);
    run_op("R2 nop opcode",     1, 3'd0, 32'h1, 32'h2, 16'h0, 3'd2, 1'b1, 0, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [2:0]  o;
      logic [31:0] a, b;
      logic [15:0] im;
      o  = 3'($urandom_range(0, 7));
      a  = $urandom;
      b  = ($urandom_range(0, 3) == 0) ? a : $urandom;
      im = ($urandom_range(0, 3) == 0) ? a[15:0] : 16'($urandom);
      if ($urandom_range(0, 3) == 0) a = {{16{im[15]}}, im};
      case (o)
        3'd1:    run_op("R2 random reg compare", 1'($urandom_range(0, 7) != 0), o, a, b, im,
                        3'($urandom), 1'($urandom), 5'($urandom), 5'($urandom), 5'($urandom));
        3'd2:    run_op("R3 random imm compare", 1'($urandom_range(0, 7) != 0), o, a, b, im,
                        3'($urandom), 1'($urandom), 5'($urandom), 5'($urandom), 5'($urandom));
        3'd3, 3'd4, 3'd5:
                 run_op("R6 random bit op", 1'($urandom_range(0, 7) != 0), o, a, b, im,
                        3'($urandom), 1'($urandom), 5'($urandom), 5'($urandom), 5'($urandom));
        3'd6, 3'd7:
                 run_op("R8 random branch", 1'($urandom_range(0, 7) != 0), o, a, b, im,
                        3'($urandom), 1'($urandom), 5'($urandom), 5'($urandom), 5'($urandom));
        default: run_op("R9 random nop", 1'($urandom_range(0, 1)), o, a, b, im,
                        3'($urandom), 1'($urandom), 5'($urandom), 5'($urandom), 5'($urandom));
      endcase
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule